// File: doc/BRIEF.md
# PLL power sequencing controller

This block runs the start, stop and retune sequences of an integer-N PLL on behalf of software. Software raises single-cycle requests to enable the PLL, to disable it, or to load a new multiplier together with the target rate it stands for. The controller drives three control bits to the PLL: an output gate, a bypass release and an active-low reset. It also drives the integer multiplier, a VCO band select, the fractional numerator and denominator, a configuration word and a droop word. It watches a lock input where the PLL has one, and otherwise waits a fixed time.

Every delay is counted in reference-clock cycles. The parameter `CYC_PER_US` gives the number of cycles in one microsecond. Release is strictly ordered: the bypass is released first, the reset is released 10 µs later, and the output gate opens only after lock is seen (or, without a lock input, 60 µs after the reset is released). A retune of a running PLL always shuts it down completely and starts it again. Before the first start, the PLL is set up once for integer mode. When the block comes out of reset, it checks whether the PLL was left running without lock.

Top module: `pll_seq_ctrl`

## Requirements
- R1: `modeOut` bit 0 is the output gate, bit 1 is the bypass release (1 = not bypassed) and bit 2 is the active-low reset. After reset, `modeOut` equals `RESET_MODE`. `enabledOut` is 1 exactly when all three bits are 1.
- R2: An accepted enable first sets bit 1. It sets bit 2 exactly 10*`CYC_PER_US` cycles later, and bit 0 is set only after that.
- R3: With `HAS_LOCK`=1, bit 0 rises on the clock edge that follows the first cycle in which `pllLock` is high during the wait. With `HAS_LOCK`=0, bit 0 rises exactly 60*`CYC_PER_US` cycles after bit 2.
- R4: With `HAS_LOCK`=1, if no lock is seen within `LOCK_TMO_CYC` cycles of reset release, `errLock` is set and all mode bits are cleared together. The next accepted enable clears `errLock`.
- R5: A disable request in the idle state clears all three mode bits on the next edge.
- R6: An enable request is acted on only when all three mode bits are 0. Otherwise it has no effect and `busy` stays low.
- R7: Before the first enable, a one-time setup writes `fracNum`=0, `fracDen`=1, `cfgOut`=`CFG_VAL` and `droopOut`=`DROOP_VAL`, and sets `vcoBand` from the held rate. The setup never runs again, so a later change of `lowBandMax` does not alter `vcoBand` at the next enable.
- R8: A set request on a running PLL (mode 111) clears all mode bits on the next edge, then updates `multOut` and `vcoBand`, then runs the full enable sequence. On a stopped PLL it only updates `multOut` and `vcoBand`.
- R9: On a set request, `vcoBand` becomes 0 when `setRate` <= `lowBandMax` and 1 otherwise.
- R10: When the block leaves reset with mode 111 while `HAS_LOCK`=1 and `pllLock`=0, it sets `errBoot`, clears all mode bits and runs the one-time setup.
- R11: `busy` is high in every state except idle, including while the block is held in reset. Requests raised while `busy` is high are ignored.
- R12: `freqMhz` always equals `multOut` * `REF_MHZ`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enReq | input | 1 | Start request pulse |
| disReq | input | 1 | Stop request pulse (wins over the others) |
| setReq | input | 1 | Retune request pulse (wins over enable) |
| setMult | input | MULT_W | Multiplier taken on a set request |
| setRate | input | RATE_W | Target rate taken on a set request |
| lowBandMax | input | RATE_W | Highest rate served by the low VCO band |
| pllLock | input | 1 | Lock status from the PLL (ignored when HAS_LOCK=0) |
| modeOut | output | 3 | {reset_n, bypass release, output gate} |
| enabledOut | output | 1 | All three mode bits set |
| busy | output | 1 | A sequence is in progress |
| multOut | output | MULT_W | Integer multiplier to the PLL |
| vcoBand | output | 1 | VCO band select, 1 = high band |
| fracNum | output | FRAC_W | Fractional numerator |
| fracDen | output | FRAC_W | Fractional denominator |
| cfgOut | output | CFG_W | Configuration word |
| droopOut | output | CFG_W | Droop control word |
| freqMhz | output | MULT_W+REF_W | Reported output frequency in MHz |
| errLock | output | 1 | Lock wait timed out |
| errBoot | output | 1 | Found running but unlocked after reset |

## Verification
The bench starts the block with the PLL left fully on and unlocked. A design that trusts the leftover mode would keep the gate open and never set `errBoot` or the denominator. It measures the gap between the bypass and reset edges, and the gap from lock to gate. A design that opens the gate early, or releases reset in the same cycle as the bypass, shows up in the compared mode bits. It tests a rate equal to the band limit, where an off-by-one compare selects the high band. It also moves the band limit between two enables, which catches a setup that runs again. Requests sent in the middle of a sequence, a retune of a running PLL and a PLL that never locks check that requests are ignored while busy, that a retune is a full restart, and that the timeout clears every mode bit at once.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  typedef enum logic [2:0] {
    ST_BOOT,
    ST_IDLE,
    ST_SETUP,
    ST_UPDATE,
    ST_BYPASS,
    ST_SETTLE,
    ST_LOCKWAIT
  } seqState_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic clrMode;
    logic setByp;
    logic setRst;
    logic setGate;
    logic loadSettle;
    logic loadWait;
    logic decCnt;
    logic doSetup;
    logic capTarget;
    logic applyTarget;
    logic setErrLock;
    logic clrErrLock;
    logic setErrBoot;
  } seqStrobe_t;

endpackage

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm
  import pll_seq_pkg::*;
#(
  parameter bit HAS_LOCK = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enReq,
  input  logic       disReq,
  input  logic       setReq,
  input  logic       lockSeen,
  input  logic       modeNone,
  input  logic       modeAll,
  input  logic       cntZero,
  input  logic       initDone,
  output seqStrobe_t stb,
  output logic       busy
);

  seqState_t state, stateNext;
  logic afterEn, afterEnNext;
  logic restart, restartNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_BOOT;
      afterEn <= 1'b0;
      restart <= 1'b0;
    end else begin
      state   <= stateNext;
      afterEn <= afterEnNext;
      restart <= restartNext;
    end
  end

  always_comb begin
    stb         = '0;
    stateNext   = state;
    afterEnNext = afterEn;
    restartNext = restart;
    unique case (state)
      ST_BOOT: begin
        if (!modeAll) begin
          stateNext   = ST_SETUP;
          afterEnNext = 1'b0;
        end else if (HAS_LOCK && !lockSeen) begin
          stb.clrMode    = 1'b1;
          stb.setErrBoot = 1'b1;
          stateNext      = ST_SETUP;
          afterEnNext    = 1'b0;
        end else begin
          stateNext = ST_IDLE;
        end
      end
      ST_SETUP: begin
        stb.doSetup = 1'b1;
        stateNext   = afterEn ? ST_BYPASS : ST_IDLE;
      end
      ST_IDLE: begin
        if (disReq) begin
          stb.clrMode = 1'b1;
        end else if (setReq) begin
          stb.capTarget = 1'b1;
          stb.clrMode   = modeAll;
          restartNext   = modeAll;
          stateNext     = ST_UPDATE;
        end else if (enReq && modeNone) begin
          afterEnNext = 1'b1;
          stateNext   = initDone ? ST_BYPASS : ST_SETUP;
        end
      end
      ST_UPDATE: begin
        stb.applyTarget = 1'b1;
        if (restart) begin
          afterEnNext = 1'b1;
          stateNext   = initDone ? ST_BYPASS : ST_SETUP;
        end else begin
          stateNext = ST_IDLE;
        end
      end
      ST_BYPASS: begin
        stb.setByp     = 1'b1;
        stb.loadSettle = 1'b1;
        stb.clrErrLock = 1'b1;
        stateNext      = ST_SETTLE;
      end
      ST_SETTLE: begin
        if (cntZero) begin
          stb.setRst   = 1'b1;
          stb.loadWait = 1'b1;
          stateNext    = ST_LOCKWAIT;
        end else begin
          stb.decCnt = 1'b1;
        end
      end
      ST_LOCKWAIT: begin
        if (HAS_LOCK && lockSeen) begin
          stb.setGate = 1'b1;
          stateNext   = ST_IDLE;
        end else if (cntZero) begin
          if (HAS_LOCK) begin
            stb.setErrLock = 1'b1;
            stb.clrMode    = 1'b1;
          end else begin
            stb.setGate = 1'b1;
          end
          stateNext = ST_IDLE;
        end else begin
          stb.decCnt = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/pll_seq_datapath.sv
module pll_seq_datapath
  import pll_seq_pkg::*;
#(
  parameter int          MULT_W     = 8,
  parameter int          RATE_W     = 16,
  parameter int          FRAC_W     = 8,
  parameter int          CFG_W      = 16,
  parameter int          CNT_W      = 9,
  parameter int          SETTLE_CYC = 40,
  parameter int          WAIT_CYC   = 400,
  parameter logic [2:0]  RESET_MODE = 3'b111,
  parameter int          RESET_MULT = 1,
  parameter int          CFG_VAL    = 0,
  parameter int          DROOP_VAL  = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        stb,
  input  logic [MULT_W-1:0] setMult,
  input  logic [RATE_W-1:0] setRate,
  input  logic [RATE_W-1:0] lowBandMax,
  output logic [2:0]        modeReg,
  output logic [MULT_W-1:0] multReg,
  output logic              bandReg,
  output logic [FRAC_W-1:0] fracNumReg,
  output logic [FRAC_W-1:0] fracDenReg,
  output logic [CFG_W-1:0]  cfgReg,
  output logic [CFG_W-1:0]  droopReg,
  output logic              errLockReg,
  output logic              errBootReg,
  output logic              modeNone,
  output logic              modeAll,
  output logic              cntZero,
  output logic              initDone
);

  localparam logic [CNT_W-1:0] SETTLE_LOAD = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] WAIT_LOAD   = CNT_W'(WAIT_CYC - 1);

  logic [CNT_W-1:0]  cnt;
  logic [MULT_W-1:0] pendMult;
  logic [RATE_W-1:0] pendRate;
  logic [RATE_W-1:0] rateReg;

  // Mode bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg <= RESET_MODE;
    end else if (stb.clrMode) begin
      modeReg <= 3'b000;
    end else begin
      if (stb.setByp)  modeReg[1] <= 1'b1;
      if (stb.setRst)  modeReg[2] <= 1'b1;
      if (stb.setGate) modeReg[0] <= 1'b1;
    end
  end

  // Shared delay counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cnt <= '0;
    else if (stb.loadSettle) cnt <= SETTLE_LOAD;
    else if (stb.loadWait)   cnt <= WAIT_LOAD;
    else if (stb.decCnt)     cnt <= cnt - 1'b1;
  end

  // Target multiplier, rate and band
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendMult <= '0;
      pendRate <= '0;
      multReg  <= MULT_W'(RESET_MULT);
      rateReg  <= '0;
      bandReg  <= 1'b0;
    end else begin
      if (stb.capTarget) begin
        pendMult <= setMult;
        pendRate <= setRate;
      end
      if (stb.applyTarget) begin
        multReg <= pendMult;
        rateReg <= pendRate;
        bandReg <= (pendRate > lowBandMax);
      end else if (stb.doSetup) begin
        bandReg <= (rateReg > lowBandMax);
      end
    end
  end

  // One-time integer-mode setup
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fracNumReg <= '0;
      fracDenReg <= '0;
      cfgReg     <= '0;
      droopReg   <= '0;
      initDone   <= 1'b0;
    end else if (stb.doSetup) begin
      fracNumReg <= '0;
      fracDenReg <= FRAC_W'(1);
      cfgReg     <= CFG_W'(CFG_VAL);
      droopReg   <= CFG_W'(DROOP_VAL);
      initDone   <= 1'b1;
    end
  end

  // Error flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errLockReg <= 1'b0;
      errBootReg <= 1'b0;
    end else begin
      if (stb.setErrLock)      errLockReg <= 1'b1;
      else if (stb.clrErrLock) errLockReg <= 1'b0;
      if (stb.setErrBoot)      errBootReg <= 1'b1;
    end
  end

  assign modeNone = (modeReg == 3'b000);
  assign modeAll  = (modeReg == 3'b111);
  assign cntZero  = (cnt == '0);

endmodule

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl
  import pll_seq_pkg::*;
#(
  parameter int         CYC_PER_US   = 4,
  parameter bit         HAS_LOCK     = 1'b1,
  parameter int         LOCK_TMO_CYC = 400,
  parameter int         MULT_W       = 8,
  parameter int         RATE_W       = 16,
  parameter int         FRAC_W       = 8,
  parameter int         CFG_W        = 16,
  parameter int         REF_MHZ      = 19,
  parameter int         REF_W        = $clog2(REF_MHZ + 1),
  parameter logic [2:0] RESET_MODE   = 3'b111,
  parameter int         RESET_MULT   = 1,
  parameter int         CFG_VAL      = 16'h4A21,
  parameter int         DROOP_VAL    = 16'h0108
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    enReq,
  input  logic                    disReq,
  input  logic                    setReq,
  input  logic [MULT_W-1:0]       setMult,
  input  logic [RATE_W-1:0]       setRate,
  input  logic [RATE_W-1:0]       lowBandMax,
  input  logic                    pllLock,
  output logic [2:0]              modeOut,
  output logic                    enabledOut,
  output logic                    busy,
  output logic [MULT_W-1:0]       multOut,
  output logic                    vcoBand,
  output logic [FRAC_W-1:0]       fracNum,
  output logic [FRAC_W-1:0]       fracDen,
  output logic [CFG_W-1:0]        cfgOut,
  output logic [CFG_W-1:0]        droopOut,
  output logic [MULT_W+REF_W-1:0] freqMhz,
  output logic                    errLock,
  output logic                    errBoot
);

  localparam int SETTLE_CYC = 10 * CYC_PER_US;
  localparam int FIX_CYC    = 60 * CYC_PER_US;
  localparam int WAIT_CYC   = HAS_LOCK ? LOCK_TMO_CYC : FIX_CYC;
  localparam int MAX_CYC    = (SETTLE_CYC > WAIT_CYC) ? SETTLE_CYC : WAIT_CYC;
  localparam int CNT_W      = $clog2(MAX_CYC + 1);
  localparam int FREQ_W     = MULT_W + REF_W;

  seqStrobe_t stb;
  logic lockSeen, modeNone, modeAll, cntZero, initDone;

  generate
    if (HAS_LOCK) begin : gLock
      assign lockSeen = pllLock;
    end else begin : gNoLock
      assign lockSeen = 1'b0;
    end
  endgenerate

  pll_seq_fsm #(.HAS_LOCK(HAS_LOCK)) uFsm (
    .clk(clk), .rstN(rstN),
    .enReq(enReq), .disReq(disReq), .setReq(setReq),
    .lockSeen(lockSeen), .modeNone(modeNone), .modeAll(modeAll),
    .cntZero(cntZero), .initDone(initDone),
    .stb(stb), .busy(busy)
  );

  pll_seq_datapath #(
    .MULT_W(MULT_W), .RATE_W(RATE_W), .FRAC_W(FRAC_W), .CFG_W(CFG_W),
    .CNT_W(CNT_W), .SETTLE_CYC(SETTLE_CYC), .WAIT_CYC(WAIT_CYC),
    .RESET_MODE(RESET_MODE), .RESET_MULT(RESET_MULT),
    .CFG_VAL(CFG_VAL), .DROOP_VAL(DROOP_VAL)
  ) uDp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .setMult(setMult), .setRate(setRate), .lowBandMax(lowBandMax),
    .modeReg(modeOut), .multReg(multOut), .bandReg(vcoBand),
    .fracNumReg(fracNum), .fracDenReg(fracDen),
    .cfgReg(cfgOut), .droopReg(droopOut),
    .errLockReg(errLock), .errBootReg(errBoot),
    .modeNone(modeNone), .modeAll(modeAll), .cntZero(cntZero),
    .initDone(initDone)
  );

  assign enabledOut = modeAll;
  assign freqMhz    = FREQ_W'(multOut) * FREQ_W'(REF_MHZ);

endmodule

// File: rtl/pll_seq_ctrl_chk.sv
module pll_seq_ctrl_chk #(
  parameter bit HAS_LOCK = 1'b1,
  parameter int MULT_W   = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              disReq,
  input logic              setReq,
  input logic              pllLock,
  input logic              busy,
  input logic              errLock,
  input logic [2:0]        modeOut,
  input logic [MULT_W-1:0] multOut
);

  AST_DISABLE_ATOMIC: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && disReq) |=> (modeOut == 3'b000)); // R5

  AST_RESET_AFTER_BYPASS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modeOut[2]) |-> $past(modeOut[1])); // R2

  AST_GATE_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    (HAS_LOCK && $rose(modeOut[0])) |-> $past(pllLock)); // R3

  AST_TIMEOUT_CLEARS_MODE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errLock) |-> (modeOut == 3'b000)); // R4

  AST_MULT_HELD_IN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !setReq) |=> $stable(multOut)); // R8

  AST_BUSY_IN_SEQUENCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modeOut[1]) |-> busy); // R11

endmodule

bind pll_seq_ctrl pll_seq_ctrl_chk #(.HAS_LOCK(HAS_LOCK), .MULT_W(MULT_W)) uChk (
  .clk(clk), .rstN(rstN), .disReq(disReq), .setReq(setReq),
  .pllLock(pllLock), .busy(busy), .errLock(errLock),
  .modeOut(modeOut), .multOut(multOut)
);

// File: tb/tb_pll_seq_ctrl.sv
module tb_pll_seq_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int CPU        = 4;
  localparam int TMO        = 400;
  localparam int REF        = 19;
  localparam int SETTLE     = 10 * CPU;
  localparam int FIXWAIT    = 60 * CPU;
  localparam int LOCK_DLY   = 25;
  localparam int CFGV       = 16'h4A21;
  localparam int DROOPV     = 16'h0108;

  localparam int PH_BOOT = 0, PH_IDLE = 1, PH_SETUP = 2, PH_UPD = 3,
                 PH_BYP = 4, PH_SETTLE = 5, PH_WAIT = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enReq = 0, disReq = 0, setReq = 0, pllLock = 0;
  logic [7:0]  setMult = 0;
  logic [15:0] setRate = 0;
  logic [15:0] lowBandMax = 16'd1000;
  logic [2:0]  modeOut;
  logic        enabledOut, busy, vcoBand, errLock, errBoot;
  logic [7:0]  multOut, fracNum, fracDen;
  logic [15:0] cfgOut, droopOut;
  logic [12:0] freqMhz;

  logic enB = 0;
  logic [2:0] modeB;
  logic enabledB, busyB, bandB, errLockB, errBootB;
  logic [7:0] multB, numB, denB;
  logic [15:0] cfgB, droopB;
  logic [12:0] freqB;

  int checks = 0, failures = 0, cyc = 0;
  bit finished = 0, broken = 1;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pll_seq_ctrl #(.CYC_PER_US(CPU), .HAS_LOCK(1'b1), .LOCK_TMO_CYC(TMO),
                 .REF_MHZ(REF), .RESET_MODE(3'b111)) dut (
    .clk(clk), .rstN(rstN), .enReq(enReq), .disReq(disReq), .setReq(setReq),
    .setMult(setMult), .setRate(setRate), .lowBandMax(lowBandMax),
    .pllLock(pllLock), .modeOut(modeOut), .enabledOut(enabledOut),
    .busy(busy), .multOut(multOut), .vcoBand(vcoBand), .fracNum(fracNum),
    .fracDen(fracDen), .cfgOut(cfgOut), .droopOut(droopOut),
    .freqMhz(freqMhz), .errLock(errLock), .errBoot(errBoot));

  pll_seq_ctrl #(.CYC_PER_US(CPU), .HAS_LOCK(1'b0), .LOCK_TMO_CYC(TMO),
                 .REF_MHZ(REF), .RESET_MODE(3'b000)) dutNoLock (
    .clk(clk), .rstN(rstN), .enReq(enB), .disReq(1'b0), .setReq(1'b0),
    .setMult(8'd0), .setRate(16'd0), .lowBandMax(16'd0),
    .pllLock(1'b0), .modeOut(modeB), .enabledOut(enabledB),
    .busy(busyB), .multOut(multB), .vcoBand(bandB), .fracNum(numB),
    .fracDen(denB), .cfgOut(cfgB), .droopOut(droopB),
    .freqMhz(freqB), .errLock(errLockB), .errBoot(errBootB));

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // PLL model plus edge timestamps, updated away from the active edge
  int lockCnt = 0;
  int tByp = -1, tRst = -1, tGate = -1, tLock = -1, tRstB = -1, tGateB = -1;
  logic [2:0] prevMode = 3'b111, prevModeB = 3'b000;
  logic prevLock = 0;
  always @(negedge clk) begin
    cyc++;
    if (!prevMode[1] && modeOut[1]) tByp = cyc;
    if (!prevMode[2] && modeOut[2]) tRst = cyc;
    if (!prevMode[0] && modeOut[0]) tGate = cyc;
    if (!prevModeB[2] && modeB[2]) tRstB = cyc;
    if (!prevModeB[0] && modeB[0]) tGateB = cyc;
    prevMode = modeOut;
    prevModeB = modeB;
    if (!rstN || !(modeOut[2] && modeOut[1])) lockCnt = 0;
    else lockCnt++;
    pllLock = !broken && (lockCnt >= LOCK_DLY);
    if (pllLock && !prevLock) tLock = cyc;
    prevLock = pllLock;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog: actual=%0d expected=<100000 cycles", cyc);
      finish_run();
    end
  end

  // Behavioural reference model, stepped on each active edge
  int ph, cnt;
  bit goEn, restartM, initM, eLock, eBoot, band;
  int mode, mult, rate, pMult, pRate, den, cfg, droop;
  always @(posedge clk) begin
    if (!rstN) begin
      ph = PH_BOOT; mode = 7; mult = 1; rate = 0; band = 0; den = 0;
      cfg = 0; droop = 0; initM = 0; eLock = 0; eBoot = 0; goEn = 0; cnt = 0;
    end else begin
      case (ph)
        PH_BOOT: begin
          goEn = 0;
          if (mode != 7) ph = PH_SETUP;
          else if (!pllLock) begin mode = 0; eBoot = 1; ph = PH_SETUP; end
          else ph = PH_IDLE;
        end
        PH_SETUP: begin
          den = 1; cfg = CFGV; droop = DROOPV; initM = 1;
          band = (rate > int'(lowBandMax));
          ph = goEn ? PH_BYP : PH_IDLE;
        end
        PH_IDLE: begin
          if (disReq) mode = 0;
          else if (setReq) begin
            pMult = int'(setMult); pRate = int'(setRate);
            restartM = (mode == 7);
            if (mode == 7) mode = 0;
            ph = PH_UPD;
          end else if (enReq && mode == 0) begin
            goEn = 1; ph = initM ? PH_BYP : PH_SETUP;
          end
        end
        PH_UPD: begin
          mult = pMult; rate = pRate; band = (pRate > int'(lowBandMax));
          if (restartM) begin goEn = 1; ph = initM ? PH_BYP : PH_SETUP; end
          else ph = PH_IDLE;
        end
        PH_BYP: begin
          mode = mode | 2; cnt = SETTLE - 1; eLock = 0; ph = PH_SETTLE;
        end
        PH_SETTLE: begin
          if (cnt == 0) begin mode = mode | 4; cnt = TMO - 1; ph = PH_WAIT; end
          else cnt--;
        end
        default: begin
          if (pllLock) begin mode = mode | 1; ph = PH_IDLE; end
          else if (cnt == 0) begin eLock = 1; mode = 0; ph = PH_IDLE; end
          else cnt--;
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (rstN && !finished && cyc > 1) begin
      chk("R1", "mode", 32'(modeOut), 32'(mode));
      chk("R1", "enabled", 32'(enabledOut), 32'(mode == 7));
      chk("R11", "busy", 32'(busy), 32'(ph != PH_IDLE));
      chk("R8", "mult", 32'(multOut), 32'(mult));
      chk("R9", "band", 32'(vcoBand), 32'(band));
      chk("R7", "den", 32'(fracDen), 32'(den));
      chk("R7", "cfg", 32'(cfgOut), 32'(cfg));
      chk("R7", "droop", 32'(droopOut), 32'(droop));
      chk("R4", "errLock", 32'(errLock), 32'(eLock));
      chk("R10", "errBoot", 32'(errBoot), 32'(eBoot));
      chk("R12", "freq", 32'(freqMhz), 32'(mult * REF));
    end
  end

  task automatic pulse_en();
    @(negedge clk); enReq = 1; @(negedge clk); enReq = 0;
  endtask
  task automatic pulse_dis();
    @(negedge clk); disReq = 1; @(negedge clk); disReq = 0;
  endtask
  task automatic pulse_set(input int m, input int r);
    @(negedge clk); setReq = 1; setMult = 8'(m); setRate = 16'(r);
    @(negedge clk); setReq = 0;
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3);
    chk("R1", "reset mode", 32'(modeOut), 32'h7);
    chk("R11", "busy in reset", 32'(busy), 32'h1);
    rstN = 1;
    idle(4);
    chk("R10", "boot error flagged", 32'(errBoot), 32'h1);
    chk("R10", "boot mode cleared", 32'(modeOut), 32'h0);
    chk("R7", "numerator zero", 32'(fracNum), 32'h0);
    broken = 0;

    pulse_set(20, 500);
    idle(3);
    chk("R8", "stopped retune keeps mode", 32'(modeOut), 32'h0);
    chk("R8", "stopped retune multiplier", 32'(multOut), 32'd20);

    pulse_en();
    idle(100);
    chk("R2", "bypass-to-reset gap", 32'(tRst - tByp), 32'(SETTLE));
    chk("R3", "lock-to-gate gap", 32'(tGate - tLock), 32'h1);
    chk("R1", "enabled after start", 32'(enabledOut), 32'h1);

    @(negedge clk); enReq = 1; @(negedge clk); enReq = 0;
    chk("R6", "enable on running PLL not busy", 32'(busy), 32'h0);

    @(negedge clk); setReq = 1; setMult = 8'd30; setRate = 16'd1500;
    @(negedge clk); setReq = 0;
    chk("R8", "running retune clears mode", 32'(modeOut), 32'h0);
    idle(100);
    chk("R8", "retune restarted", 32'(modeOut), 32'h7);
    chk("R9", "high band", 32'(vcoBand), 32'h1);
    chk("R12", "frequency", 32'(freqMhz), 32'(30 * REF));

    @(negedge clk); disReq = 1; @(negedge clk); disReq = 0;
    chk("R5", "disable same edge", 32'(modeOut), 32'h0);

    lowBandMax = 16'd2000;
    pulse_en();
    idle(5);
    pulse_dis();
    idle(100);
    chk("R11", "disable while busy ignored", 32'(modeOut), 32'h7);
    chk("R7", "setup not rerun, band kept", 32'(vcoBand), 32'h1);

    pulse_dis();
    pulse_set(40, 2000);
    idle(3);
    chk("R9", "rate equal to limit is low band", 32'(vcoBand), 32'h0);
    pulse_set(40, 2001);
    idle(3);
    chk("R9", "rate above limit is high band", 32'(vcoBand), 32'h1);

    broken = 1;
    pulse_en();
    idle(SETTLE + TMO + 20);
    chk("R4", "timeout error", 32'(errLock), 32'h1);
    chk("R4", "timeout mode cleared", 32'(modeOut), 32'h0);
    broken = 0;
    pulse_en();
    idle(100);
    chk("R4", "error cleared on new enable", 32'(errLock), 32'h0);

    @(negedge clk); enB = 1; @(negedge clk); enB = 0;
    idle(SETTLE + FIXWAIT + 20);
    chk("R3", "fixed wait gap without lock", 32'(tGateB - tRstB), 32'(FIXWAIT));
    chk("R1", "no-lock instance enabled", 32'(enabledB), 32'h1);

    finish_run();
  end

endmodule